// File: doc/BRIEF.md
# SIMD Multimedia Sub-Op Execution Unit

This unit decodes and executes one group of 128-bit multimedia instructions. Each cycle it receives a 32-bit instruction word, the PC of that instruction, two 128-bit source operands (`rs_val`, `rt_val`) and a valid strobe. One clock later it presents a 128-bit result, the destination register index, a write enable, and a trap flag. When the trap flag is raised, the unit also returns the faulting PC and instruction word.

The group is recognised from two fields: the major opcode in bits [31:26] and the function field in bits [5:0]. Inside the group, the 5-bit shift-amount field in bits [10:6] picks the sub-operation. Decoding is narrow: only three sub-op codes on an explicit allow-list execute. Every other code in the group raises an unsupported-opcode trap and writes nothing. Instructions outside the group pass through silently, so that other decoders can claim them. The register file, the pipeline and exception vectoring live outside this block.

Top module: `simd_subop_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: A cycle in which `in_valid` is low produces all-zero outputs on the following cycle, whatever is on the other inputs.
- R3: The group is recognised only when bits [31:26] equal 6'h1C and bits [5:0] equal 6'h29. A valid instruction outside the group produces zero result, zero `out_rd`, no write and no trap.
- R4: For a group instruction, `out_rd` carries bits [15:11] of the instruction. Bits [25:21] name rs and bits [20:16] name rt.
- R5: Sub-op 5'h0E (upper-doubleword copy) gives result[63:0] = rs[127:64] and result[127:64] = rt[127:64], and writes all 128 bits.
- R6: Sub-op 5'h13 gives the bitwise NOR of rs and rt over all 128 bits.
- R7: Sub-op 5'h1B uses rt only. Within each 64-bit doubleword, result halfword i (bits 16i+15:16i) takes source halfword 3-i of the same doubleword.
- R8: Any other shift-field value inside the group raises `out_trap` with `out_wen` low and a zero result. `out_trap_pc` and `out_trap_instr` then return the instruction's PC and word. When there is no trap, both of these outputs are zero.
- R9: `out_wen` stays low whenever the destination index is 0, even for a supported sub-op. The result is still presented.
- R10: All outputs are registered exactly one cycle after the input cycle they belong to. Back-to-back valid cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | PC of the instruction |
| rs_val | input | 128 | First source operand |
| rt_val | input | 128 | Second source operand |
| out_result | output | 128 | Result value |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Register write enable |
| out_trap | output | 1 | Unsupported-opcode trap |
| out_trap_pc | output | 32 | Faulting PC when trapping, else zero |
| out_trap_instr | output | 32 | Faulting instruction when trapping, else zero |

## Verification
Each of the three supported sub-ops is driven with operands whose halfwords are all distinct. With such operands, a swapped doubleword, a swapped source or a reversal in the wrong direction each produces a different result. The NOR is also driven with all-zero, all-one and alternating operands. The reversal is given a non-zero rs, to show that rs is not used. Shift-field codes at both ends of the range and next to the allowed codes separate the allow-list from a looser decode. Near-miss opcode and function values separate full group matching from a partial match. Runs with rd = 0, idle cycles and back-to-back instructions show write suppression and the one-cycle timing.

// File: rtl/simd_subop_unit.sv
module simd_subop_unit (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  in_instr,
  input  logic [31:0]  in_pc,
  input  logic [127:0] rs_val,
  input  logic [127:0] rt_val,
  output logic [127:0] out_result,
  output logic [4:0]   out_rd,
  output logic         out_wen,
  output logic         out_trap,
  output logic [31:0]  out_trap_pc,
  output logic [31:0]  out_trap_instr
);
  localparam int         HW       = 16;
  localparam int         DW       = 64;
  localparam int         NDW      = 128 / DW;
  localparam int         NHW      = DW / HW;
  localparam logic [5:0] MAJOR    = 6'h1C;
  localparam logic [5:0] FUNC     = 6'h29;
  localparam logic [4:0] SA_UCOPY = 5'h0E;
  localparam logic [4:0] SA_NOR   = 5'h13;
  localparam logic [4:0] SA_HREV  = 5'h1B;

  logic [4:0]   sel, rd;
  logic         in_group, known;
  logic [127:0] hrev, res;

  assign sel      = in_instr[10:6];
  assign rd       = in_instr[15:11];
  assign in_group = in_valid && in_instr[31:26] == MAJOR && in_instr[5:0] == FUNC;
  assign known    = sel == SA_UCOPY || sel == SA_NOR || sel == SA_HREV;

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    for (genvar h = 0; h < NHW; h++) begin : g_hw
      assign hrev[d*DW + h*HW +: HW] = rt_val[d*DW + (NHW-1-h)*HW +: HW];
    end
  end

  always_comb begin
    case (sel)
      SA_UCOPY: res = {rt_val[127:64], rs_val[127:64]};
      SA_NOR:   res = ~(rs_val | rt_val);
      SA_HREV:  res = hrev;
      default:  res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result     <= '0;
      out_rd         <= '0;
      out_wen        <= 1'b0;
      out_trap       <= 1'b0;
      out_trap_pc    <= '0;
      out_trap_instr <= '0;
    end else begin
      out_result     <= (in_group && known) ? res : '0;
      out_rd         <= in_group ? rd : '0;
      out_wen        <= in_group && known && rd != 5'd0;
      out_trap       <= in_group && !known;
      out_trap_pc    <= (in_group && !known) ? in_pc : '0;
      out_trap_instr <= (in_group && !known) ? in_instr : '0;
    end
  end
endmodule

module simd_subop_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic [31:0] in_pc,
  input logic [4:0]  out_rd,
  input logic        out_wen,
  input logic        out_trap,
  input logic [31:0] out_trap_pc,
  input logic [31:0] out_trap_instr
);
  logic grp, allowed;
  assign grp     = in_instr[31:26] == 6'h1C && in_instr[5:0] == 6'h29;
  assign allowed = in_instr[10:6] == 5'h0E || in_instr[10:6] == 5'h13 || in_instr[10:6] == 5'h1B;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_wen && !out_trap && out_rd == 5'd0);
  // R3
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !grp |=> !out_wen && !out_trap);
  // R8
  trap_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && grp && !allowed |=> out_trap && !out_wen
      && out_trap_pc == $past(in_pc) && out_trap_instr == $past(in_instr));
  // R8
  trap_excl_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_trap && out_wen));
  // R9
  rd_zero_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_rd != 5'd0);
  // R10
  supported_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && grp && allowed && in_instr[15:11] != 5'd0 |=> out_wen && out_rd == $past(in_instr[15:11]));
endmodule

bind simd_subop_unit simd_subop_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .in_pc(in_pc),
  .out_rd(out_rd), .out_wen(out_wen), .out_trap(out_trap),
  .out_trap_pc(out_trap_pc), .out_trap_instr(out_trap_instr)
);

// File: tb/simd_subop_unit_bench.sv
module simd_subop_unit_bench;
  localparam int PERIOD = 10;

  logic         clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0]  in_instr = 0, in_pc = 0;
  logic [127:0] rs_val = 0, rt_val = 0;
  logic [127:0] out_result;
  logic [4:0]   out_rd;
  logic         out_wen, out_trap;
  logic [31:0]  out_trap_pc, out_trap_instr;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  simd_subop_unit u_simd_subop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .in_pc(in_pc),
    .rs_val(rs_val), .rt_val(rt_val), .out_result(out_result), .out_rd(out_rd),
    .out_wen(out_wen), .out_trap(out_trap), .out_trap_pc(out_trap_pc),
    .out_trap_instr(out_trap_instr)
  );

  typedef struct {
    logic [127:0] res;
    logic [4:0]   rd;
    logic         wen, trap;
    logic [31:0]  tpc, tins;
    string        tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [4:0] sa, input logic [5:0] fn);
    return {op, rs, rt, rd, sa, fn};
  endfunction

  function automatic exp_t model(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                                 input logic [127:0] a, input logic [127:0] b, input string tag);
    exp_t e;
    int sa;
    e.res = '0; e.rd = '0; e.wen = 0; e.trap = 0; e.tpc = '0; e.tins = '0; e.tag = tag;
    sa = int'(ins[10:6]);
    if (v && ins[31:26] == 6'd28 && ins[5:0] == 6'd41) begin
      e.rd = ins[15:11];
      if (sa == 14) begin
        e.res[63:0]   = a[127:64];
        e.res[127:64] = b[127:64];
      end else if (sa == 19) begin
        for (int i = 0; i < 128; i++) e.res[i] = !(a[i] || b[i]);
      end else if (sa == 27) begin
        for (int d = 0; d < 2; d++)
          for (int h = 0; h < 4; h++)
            e.res[d*64 + h*16 +: 16] = b[d*64 + (3-h)*16 +: 16];
      end else begin
        e.trap = 1; e.tpc = pc; e.tins = ins;
      end
      e.wen = !e.trap && e.rd != 0;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(e.tag, "result", out_result, e.res);
    chk(e.tag, "rd", 128'(out_rd), 128'(e.rd));
    chk(e.tag, "wen", 128'(out_wen), 128'(e.wen));
    chk(e.tag, "trap", 128'(out_trap), 128'(e.trap));
    chk(e.tag, "trap_pc", 128'(out_trap_pc), 128'(e.tpc));
    chk(e.tag, "trap_instr", 128'(out_trap_instr), 128'(e.tins));
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                      input logic [127:0] a, input logic [127:0] b, input string tag);
    in_valid = v; in_instr = ins; in_pc = pc; rs_val = a; rt_val = b;
    q.push_back(model(v, ins, pc, a, b, tag));
    @(negedge clk);
    compare(q.pop_front());
  endtask

  localparam logic [127:0] PA = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
  localparam logic [127:0] PB = 128'hf0e1_d2c3_b4a5_9687_7869_5a4b_3c2d_1e0f;

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: outputs during reset, with a trapping instruction offered
    in_valid = 1; in_instr = mk(6'h1C, 0, 8, 3, 5'h1A, 6'h29); in_pc = 32'h1234;
    repeat (3) @(negedge clk);
    compare(model(0, 0, 0, 0, 0, "R1"));
    rst_n = 1;
    in_valid = 0;

    // R2: group instruction on the bus with strobe low
    step(0, mk(6'h1C, 1, 2, 4, 5'h13, 6'h29), 32'h40, PA, PB, "R2");
    // R5 / R4: upper-doubleword copy
    step(1, mk(6'h1C, 1, 2, 7, 5'h0E, 6'h29), 32'h100, PA, PB, "R5");
    step(1, mk(6'h1C, 9, 3, 31, 5'h0E, 6'h29), 32'h104, PB, PA, "R4");
    // R6: NOR patterns
    step(1, mk(6'h1C, 1, 2, 5, 5'h13, 6'h29), 32'h108, PA, PB, "R6");
    step(1, mk(6'h1C, 1, 2, 5, 5'h13, 6'h29), 32'h10C, '0, '0, "R6");
    step(1, mk(6'h1C, 1, 2, 5, 5'h13, 6'h29), 32'h110, '1, '0, "R6");
    step(1, mk(6'h1C, 1, 2, 5, 5'h13, 6'h29), 32'h114, {4{32'h5555_5555}}, {4{32'h2222_2222}}, "R6");
    // R7: halfword reversal, rs non-zero but unused
    step(1, mk(6'h1C, 0, 8, 3, 5'h1B, 6'h29), 32'h0011_0BB4, PA, PB, "R7");
    step(1, 32'h70081EE9, 32'h0011_0BB4, '1, PA, "R7");
    // R8: codes outside the allow-list
    step(1, 32'h70081EA9, 32'h0011_0BB4, PA, PB, "R8");
    step(1, mk(6'h1C, 1, 2, 3, 5'h00, 6'h29), 32'h200, PA, PB, "R8");
    step(1, mk(6'h1C, 1, 2, 3, 5'h1F, 6'h29), 32'h204, PA, PB, "R8");
    step(1, mk(6'h1C, 1, 2, 3, 5'h0F, 6'h29), 32'h208, PA, PB, "R8");
    step(1, mk(6'h1C, 1, 2, 0, 5'h12, 6'h29), 32'h20C, PA, PB, "R8");
    // R9: rd = 0 suppresses the write for every supported code
    step(1, mk(6'h1C, 1, 2, 0, 5'h0E, 6'h29), 32'h300, PA, PB, "R9");
    step(1, mk(6'h1C, 1, 2, 0, 5'h13, 6'h29), 32'h304, PA, PB, "R9");
    step(1, mk(6'h1C, 1, 2, 0, 5'h1B, 6'h29), 32'h308, PA, PB, "R9");
    // R3: near-miss opcode or function field
    step(1, mk(6'h00, 1, 2, 3, 5'h1A, 6'h29), 32'h400, PA, PB, "R3");
    step(1, mk(6'h1C, 1, 2, 3, 5'h1A, 6'h28), 32'h404, PA, PB, "R3");
    step(1, mk(6'h1D, 1, 2, 3, 5'h0E, 6'h29), 32'h408, PA, PB, "R3");
    step(1, mk(6'h1C, 1, 2, 3, 5'h13, 6'h09), 32'h40C, PA, PB, "R3");
    // R10: back-to-back mix, then idle
    for (int i = 0; i < 24; i++) begin
      logic [4:0] sa;
      sa = (i % 4 == 0) ? 5'h0E : (i % 4 == 1) ? 5'h13 : (i % 4 == 2) ? 5'h1B : 5'(i);
      step(1, mk(6'h1C, 5'(i), 5'(i+1), 5'(i), sa, 6'h29), 32'h1000 + 32'(i*4),
           PA ^ {4{32'(i*32'h0101_0101)}}, PB + 128'(i), "R10");
    end
    step(0, 0, 0, PA, PB, "R10");
    step(0, 0, 0, 0, 0, "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule